// File: doc/BRIEF.md
# I2C Master Command and Byte Engine

This block drives the two open-drain lines of an I2C bus as a master, one bus event at a time. Software writes a small control word to request an event. The event is a START, a repeated START or a STOP. A write to the data port sends one byte and captures the slave's acknowledge. Each event runs as a fixed pattern of SCL/SDA levels. The pattern is split into quarter-bit steps, and a reloadable down-counter times each step. When the event finishes, the block sets a sticky completion flag, which software clears with a pulse.

The outputs are pull-down enables: a 1 pulls the line low, and a 0 releases it to the pull-up. A pad-disable bit forces both enables to 0 and leaves the internal sequencing untouched. The block does not arbitrate, does not follow clock stretching and has no byte storage. A byte is sent exactly as written, so a 7-bit read address goes out as the address shifted left with a 1 in the LSB.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both line enables are 0, busy and done are 0, the control readback is 0 and the pad drivers are disabled.
- R2: A control write stores enable in bit 0, the command in bits 2:1 and the select/acknowledge bit in bit 3. The readback returns these fields, and enable and command keep their value until the next control write.
- R3: Command 1 with bit 3 = 0 and bit 0 = 1 makes a plain START. From a released bus, SDA falls while SCL is high, then SCL falls, and the sequence ends with both lines low.
- R4: Command 1 with bit 3 = 1 makes a repeated START. SDA is released while SCL is low, SCL rises, SDA falls while SCL is high, then SCL falls.
- R5: Command 2 (with bit 0 = 1) makes a STOP. SDA is held low, SCL rises, then SDA rises while SCL is high, and both lines end released.
- R6: A data write while enabled and idle sends the 8 bits MSB first, one per SCL high pulse, and SDA is released for a ninth pulse. A read address 0x50 therefore goes out as 0xA1.
- R7: After a byte, control bit 3 reads 1 if SDA was high (NAK) during the ninth SCL high phase and 0 if it was low (ACK). This value overwrites the select bit that was written.
- R8: done is set when any command or byte completes and is cleared by done_clr. If both happen in the same cycle, done ends set.
- R9: While the pad-disable bit is 1, both line enables are 0. When it is 0, the enables follow the sequencer's levels.
- R10: Each quarter step lasts DIV+1 cycles, where DIV is the last value written to the divider. busy is therefore high for 4(DIV+1) cycles for a command and 36(DIV+1) cycles for a byte.
- R11: Command codes 0 and 3, commands written with bit 0 = 0, data writes while enable is 0, and any write while busy start nothing.
- R12: Outside START and STOP sequences, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control word: enable, command, select |
| ctl_rdata | output | 4 | Control readback: enable, command, acknowledge |
| dat_wr | input | 1 | Data write strobe; starts a byte |
| dat_wdata | input | 8 | Byte to send |
| pad_wr | input | 1 | Pad-control write strobe |
| pad_dis | input | 1 | Pad-disable value (1 = drivers off) |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W | Quarter-step reload value |
| done_clr | input | 1 | Clears the completion flag |
| done | output | 1 | Sticky completion flag |
| busy | output | 1 | A sequence is running |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The completion of a byte and a software clear of the done flag can fall on the same clock edge. The bench provokes this by pulsing done_clr exactly in the cycle the last quarter step of a byte expires, counted from the data write. It then expects done to remain set, because the set has priority, and busy to be low. A control write arriving during the same completion is not relied on. The bench also judges the acknowledge capture against a slave that pulls SDA low and one that stays released.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [3:0]       ctl_wdata,
  output logic [3:0]       ctl_rdata,
  input  logic             dat_wr,
  input  logic [7:0]       dat_wdata,
  input  logic             pad_wr,
  input  logic             pad_dis,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             done_clr,
  output logic             done,
  output logic             busy,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam logic [1:0] S_IDLE = 2'd0, S_START = 2'd1, S_STOP = 2'd2, S_BYTE = 2'd3;
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

  logic [1:0]       st;
  logic [1:0]       qtr;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic [DIV_W-1:0] cnt, div_q;
  logic             en_q, ack_q, rs_q, nack_s, done_q, pad_off;
  logic [1:0]       cmd_q;
  logic             rest_scl, rest_sda;
  logic             scl_lvl, sda_lvl;

  wire tick     = (cnt == '0);
  wire seq_end  = tick && (qtr == 2'd3) && (st != S_BYTE || bitn == 4'd8);
  wire cmd_ok   = ctl_wr && ctl_wdata[0];

  always_comb begin
    scl_lvl = rest_scl;
    sda_lvl = rest_sda;
    case (st)
      S_START:
        if (rs_q)
          case (qtr)
            2'd0: {scl_lvl, sda_lvl} = 2'b01;
            2'd1: {scl_lvl, sda_lvl} = 2'b11;
            2'd2: {scl_lvl, sda_lvl} = 2'b10;
            default: {scl_lvl, sda_lvl} = 2'b00;
          endcase
        else
          case (qtr)
            2'd0: {scl_lvl, sda_lvl} = 2'b11;
            2'd1: {scl_lvl, sda_lvl} = 2'b10;
            default: {scl_lvl, sda_lvl} = 2'b00;
          endcase
      S_STOP:
        case (qtr)
          2'd0: {scl_lvl, sda_lvl} = 2'b00;
          2'd1: {scl_lvl, sda_lvl} = 2'b10;
          default: {scl_lvl, sda_lvl} = 2'b11;
        endcase
      S_BYTE: begin
        scl_lvl = (qtr == 2'd1) || (qtr == 2'd2);
        sda_lvl = (bitn == 4'd8) ? 1'b1 : sh[7];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      qtr      <= 2'd0;
      bitn     <= 4'd0;
      sh       <= 8'd0;
      cnt      <= '0;
      div_q    <= DIV_INIT;
      en_q     <= 1'b0;
      cmd_q    <= 2'd0;
      ack_q    <= 1'b0;
      rs_q     <= 1'b0;
      nack_s   <= 1'b0;
      done_q   <= 1'b0;
      pad_off  <= 1'b1;
      rest_scl <= 1'b1;
      rest_sda <= 1'b1;
    end else begin
      if (div_wr) div_q <= div_wdata;
      if (pad_wr) pad_off <= pad_dis;
      if (ctl_wr) {ack_q, cmd_q, en_q} <= ctl_wdata;
      if (done_clr) done_q <= 1'b0;
      if (st == S_IDLE) begin
        cnt  <= div_q;
        qtr  <= 2'd0;
        bitn <= 4'd0;
        if (cmd_ok && ctl_wdata[2:1] == 2'd1) begin
          st   <= S_START;
          rs_q <= ctl_wdata[3];
        end else if (cmd_ok && ctl_wdata[2:1] == 2'd2) begin
          st <= S_STOP;
        end else if (dat_wr && en_q) begin
          st <= S_BYTE;
          sh <= dat_wdata;
        end
      end else if (tick) begin
        cnt <= div_q;
        qtr <= qtr + 2'd1;
        if (st == S_BYTE && qtr == 2'd2 && bitn == 4'd8) nack_s <= sda_in;
        if (st == S_BYTE && qtr == 2'd3) begin
          sh   <= {sh[6:0], 1'b0};
          bitn <= bitn + 4'd1;
        end
        if (seq_end) begin
          st       <= S_IDLE;
          done_q   <= 1'b1;
          rest_scl <= scl_lvl;
          rest_sda <= sda_lvl;
          if (st == S_BYTE) ack_q <= nack_s;
        end
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign ctl_rdata = {ack_q, cmd_q, en_q};
  assign scl_oe    = !pad_off && !scl_lvl;
  assign sda_oe    = !pad_off && !sda_lvl;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [3:0] ctl_wdata,
  input logic [3:0] ctl_rdata,
  input logic       dat_wr,
  input logic       pad_wr,
  input logic       pad_dis,
  input logic       busy,
  input logic       done,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [1:0] st,
  input logic       pad_off
);
  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ctl_rdata[2:0]));

  a_r8_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_pad_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_wr && pad_dis) |=> (!scl_oe && !sda_oe));

  a_r11_noop_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !dat_wr && ctl_wr && (ctl_wdata[2:1] == 2'd0 || ctl_wdata[2:1] == 2'd3)) |=> !busy);

  a_r12_sda_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && $stable(pad_off) && !scl_oe && !$past(scl_oe)) |-> (st == 2'd1 || st == 2'd2));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .dat_wr(dat_wr), .pad_wr(pad_wr), .pad_dis(pad_dis), .busy(busy), .done(done),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .st(st), .pad_off(pad_off)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  localparam int DIV = 2;
  localparam int Q = DIV + 1;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, dat_wr = 0, pad_wr = 0, pad_dis = 0, div_wr = 0, done_clr = 0;
  logic [3:0] ctl_wdata = 0, ctl_rdata;
  logic [7:0] dat_wdata = 0, div_wdata = 0;
  logic done, busy, scl_oe, sda_oe, sda_in, slv_ack = 0;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;
  assign sda_in = !sda_oe && !slv_ack;

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .pad_wr(pad_wr), .pad_dis(pad_dis),
    .div_wr(div_wr), .div_wdata(div_wdata), .done_clr(done_clr), .done(done), .busy(busy),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  logic [1:0] lg [0:15];
  int nl = 0, ncap = 0, viol = 0;
  logic [8:0] cap = 0;
  logic [1:0] prev = 2'b11, cur;
  logic log_on = 0;

  always @(negedge clk) begin
    cur = {!scl_oe, !sda_oe};
    if (log_on && cur != prev) begin
      if (nl < 16) lg[nl] = cur;
      nl++;
      if (!prev[1] && cur[1]) begin cap = {cap[7:0], cur[0]}; ncap++; end
      if (cur[0] != prev[0] && cur[1] && prev[1]) viol++;
    end
    prev = cur;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [3:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic clr_done();
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0;
  endtask

  task automatic chk_log(string req, int n, logic [5:0] exp);
    chk({req, " change count"}, nl, n);
    for (int i = 0; i < n; i++)
      chk({req, " level step"}, lg[i], exp[5-2*i -: 2]);
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 rdata", ctl_rdata, 0);
    @(negedge clk); pad_wr = 1; pad_dis = 0; div_wr = 1; div_wdata = DIV;
    @(negedge clk); pad_wr = 0; div_wr = 0;
    chk("R9 drive idle released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_noop();
    wr_ctl(4'b0001);
    chk("R11 code0 idle", busy, 0);
    chk("R2 enable readback", ctl_rdata, 4'b0001);
    wr_ctl(4'b0111);
    chk("R11 code3 idle", busy, 0);
    wr_ctl(4'b0001);
  endtask

  task automatic run_cmd(string req, logic [3:0] v, int n, logic [5:0] exp);
    int c = 0;
    clr_done();
    nl = 0; log_on = 1;
    wr_ctl(v);
    while (busy && c < 1000) begin c++; @(negedge clk); end
    #1 log_on = 0;
    chk({req, " R10 busy cycles"}, c, 4 * Q);
    chk({req, " R8 done"}, done, 1);
    chk({req, " R2 readback"}, ctl_rdata[2:0], v[2:0]);
    chk_log(req, n, exp);
  endtask

  task automatic run_byte(string req, logic [7:0] d, logic ack, bit poke, bit collide);
    int c = 0;
    clr_done();
    slv_ack = ack; nl = 0; ncap = 0; cap = 0; viol = 0; log_on = 1;
    @(negedge clk); dat_wr = 1; dat_wdata = d;
    @(negedge clk); dat_wr = 0;
    if (collide) begin
      repeat (36 * Q - 1) @(negedge clk);
      done_clr = 1;
      @(negedge clk); done_clr = 0;
      chk({req, " R8 set beats clear"}, done, 1);
      chk({req, " R8 busy low"}, busy, 0);
    end else begin
      while (busy && c < 1000) begin
        c++;
        dat_wr = (poke && c == 5);
        dat_wdata = 8'hFF;
        @(negedge clk);
      end
      dat_wr = 0;
      chk({req, " R10 busy cycles"}, c, 36 * Q);
      chk({req, " R8 done"}, done, 1);
    end
    #1 log_on = 0; slv_ack = 0;
    chk({req, " R6 pulses"}, ncap, 9);
    chk({req, " R6 bits"}, cap, {d, 1'b1});
    chk({req, " R7 ack bit"}, ctl_rdata[3], !ack);
    chk({req, " R12 sda stable scl high"}, viol, 0);
  endtask

  task automatic t_disabled();
    int c = 0;
    wr_ctl(4'b0000);
    @(negedge clk); dat_wr = 1; dat_wdata = 8'h55;
    @(negedge clk); dat_wr = 0;
    chk("R11 data while disabled", busy, 0);
    wr_ctl(4'b0010);
    chk("R11 command while disabled", busy, 0);
  endtask

  task automatic t_pad();
    int bad = 0;
    @(negedge clk); pad_wr = 1; pad_dis = 1;
    @(negedge clk); pad_wr = 0;
    clr_done();
    wr_ctl(4'b0011);
    while (busy) begin if (scl_oe || sda_oe) bad++; @(negedge clk); end
    chk("R9 no drive when disabled", bad, 0);
    chk("R9 done still set", done, 1);
    @(negedge clk); pad_wr = 1; pad_dis = 0;
    @(negedge clk); pad_wr = 0;
    chk("R9 drive after enable", {scl_oe, sda_oe}, 2'b11);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_noop();
    run_cmd("R3 start", 4'b0011, 2, {2'b10, 2'b00, 2'b00});
    run_byte("R6 byte ack ignore-write R11", 8'hA5, 1, 1, 0);
    run_byte("R8 byte nak collision", 8'h3C, 0, 0, 1);
    clr_done();
    chk("R8 cleared", done, 0);
    run_cmd("R4 restart", 4'b1011, 3, {2'b11, 2'b10, 2'b00});
    run_byte("R6 read address", {7'h50, 1'b1}, 1, 0, 0);
    run_cmd("R5 stop", 4'b0101, 3, {2'b00, 2'b10, 2'b11});
    t_disabled();
    t_pad();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule